// File: doc/BRIEF.md
# Reconfigurable Time-Hopping Antipodal Pulse Receiver

This block is the digital baseband of an impulse-radio receiver. Each data bit is sent as one antipodal pulse per frame. The pulse sits in one slot of the frame, and a time-hopping code chooses that slot. The block takes a stream of signed converter samples whose frame alignment is already known: the first sample of every frame carries a start flag. It multiplies the samples of the selected slot by a fixed pulse template and sums them in a single correlation branch. At the end of the frame it decides one bit from the sign of that sum.

The data rate is set at run time. The slot length in samples and the number of slots per frame come in on parameter inputs, and they are taken in only when a configuration strobe is raised. The hopping codes live in two small on-chip banks. Software writes the standby bank, and the strobe makes that bank active. A change requested in the middle of a frame waits until the frame has been decided, so a bit is never computed with mixed settings.

The sample input is a valid/ready stream. The receiver holds `s_ready` low in two cases: until it has been configured for the first time, and for the one cycle in which a waiting configuration is applied. A sample is transferred only in a cycle where `s_valid` and `s_ready` are both high. The bit output has no ready signal. Each decided bit appears on `bit_data` together with a one-cycle `bit_valid` pulse, and the consumer has to take it in that cycle.

Top module: `thbpam_rx`

## Requirements
- R1: After reset `s_ready` and `bit_valid` are low. They stay low until a configuration strobe has been accepted and applied. Samples offered before that moment are not taken.
- R2: A frame is `cfg_slots` slots of `cfg_slot_len` samples each. Only transferred samples count toward the frame. Cycles with `s_valid` low do not move the frame position.
- R3: A sample adds to the correlation only if two conditions hold: its slot index equals the hopping entry of the current frame, and its position k in the slot is below 8. It then adds sample × coefficient k. The default coefficients for k = 0..7 are 1, 3, 5, 7, 7, 5, 3, 1. Samples at k ≥ 8 and samples in other slots add nothing.
- R4: The decided bit is 1 when the frame's sum is greater than zero and 0 otherwise, so a sum of zero gives 0. `bit_valid` is high for exactly the cycle after the frame's last sample is transferred. The sum starts again from zero in every frame.
- R5: Frame n uses code entry `p`. The pointer `p` is set to 0 when a configuration is applied and moves forward by one after each decided frame. When it reaches `cfg_code_len` it returns to 0; a length of 0 acts like 1.
- R6: A hopping entry equal to or above the active slot count matches no slot, so that frame always decides 0.
- R7: A strobe captures the slot length, the slot count and the code length. A strobe that carries a zero slot length or a zero slot count is ignored. When several strobes arrive before one is applied, the last one counts.
- R8: A captured configuration is applied only outside a frame. A frame that is in progress is completed and decided with the settings it started with. During the cycle in which the new settings are applied, `s_ready` is low.
- R9: A code write (`code_we`, `code_addr`, `code_slot`) goes to the standby bank. Applying a configuration swaps the banks. A code write made while a configuration is waiting to be applied is ignored.
- R10: While the receiver waits for a frame to start, a transferred sample without `s_first` is discarded. Inside a frame, `s_first` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_strobe | input | 1 | Capture the three configuration inputs |
| cfg_slot_len | input | 16 | Samples per slot |
| cfg_slots | input | 8 | Slots per frame |
| cfg_code_len | input | 5 | Number of hopping entries used before the pointer wraps |
| code_we | input | 1 | Write one hopping entry into the standby bank |
| code_addr | input | 4 | Entry index |
| code_slot | input | 8 | Slot index stored in the entry |
| s_valid | input | 1 | Sample stream valid |
| s_ready | output | 1 | Sample stream ready |
| s_first | input | 1 | Marks the first sample of a frame |
| s_sample | input | 8 | Signed sample |
| bit_valid | output | 1 | One-cycle strobe for a decided bit |
| bit_data | output | 1 | Decided bit |

## Verification
The bench targets these cases:
- A configuration change in the middle of a frame. A design that applied it at once would decide the current bit over the wrong slot or length.
- A code write made while a change is waiting. A design that accepted it would hop to a different slot in the next frame and flip the bit.
- Energy placed beyond the template window, and strong noise of the opposite sign in the other slots. A correlator that summed the wrong samples would flip the decision.
- A zero sum, an out-of-range hopping entry, a dropped sample without a start flag, a start flag inside a frame, a strobe with a zero field, and two strobes where the second must win. Each of these changes the bit value, the bit count or the frame length whenever the design gets it wrong.

// File: rtl/thbpam_pkg.sv
package thbpam_pkg;
  localparam int TC_W       = 16;
  localparam int NC_W       = 8;
  localparam int CODE_AW    = 4;
  localparam int CODE_DEPTH = 1 << CODE_AW;
  localparam int LEN_W      = CODE_AW + 1;
  localparam int SMP_W      = 8;
  localparam int COEF_W     = 4;
  localparam int TMPL_LEN   = 8;
  localparam int TMPL_AW    = $clog2(TMPL_LEN);
  localparam int PROD_W     = SMP_W + COEF_W;
  localparam int ACC_W      = PROD_W + TMPL_AW + 1;

  typedef struct packed {
    logic [TC_W-1:0]  tc;
    logic [NC_W-1:0]  nc;
    logic [LEN_W-1:0] len;
  } rx_cfg_t;

  typedef enum logic {FR_WAIT = 1'b0, FR_BUSY = 1'b1} fr_state_e;
endpackage

// File: rtl/thbpam_cfg.sv
module thbpam_cfg
  import thbpam_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    strobe,
  input  rx_cfg_t new_cfg,
  input  logic    in_frame,
  output rx_cfg_t act_cfg,
  output logic    active,
  output logic    pend,
  output logic    apply
);
  rx_cfg_t shadow;
  logic    take_req;

  // zero-length slots or frames are rejected outright
  assign take_req = strobe && (new_cfg.tc != '0) && (new_cfg.nc != '0);
  // a waiting change lands only between frames
  assign apply    = pend && !in_frame;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow  <= '0;
      act_cfg <= '0;
      active  <= 1'b0;
      pend    <= 1'b0;
    end else begin
      if (apply) begin
        act_cfg <= shadow;
        active  <= 1'b1;
      end
      if (take_req) begin
        shadow <= new_cfg;
        pend   <= 1'b1;
      end else if (apply) begin
        pend <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/thbpam_code.sv
module thbpam_code
  import thbpam_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               we,
  input  logic [CODE_AW-1:0] addr,
  input  logic [NC_W-1:0]    wdata,
  input  logic               hold,
  input  logic               swap,
  input  logic               adv,
  input  logic [LEN_W-1:0]   len,
  output logic [NC_W-1:0]    hop
);
  localparam int NBANK = 2;

  logic               bank_sel;
  logic [CODE_AW-1:0] rd_ptr;
  logic [LEN_W-1:0]   ptr_inc;
  logic [NC_W-1:0]    rd_word [NBANK];

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    logic [NC_W-1:0] words [CODE_DEPTH];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        for (int i = 0; i < CODE_DEPTH; i++) words[i] <= '0;
      end else if (we && !hold && (bank_sel != 1'(b))) begin
        words[addr] <= wdata;
      end
    end
    assign rd_word[b] = words[rd_ptr];
  end

  assign ptr_inc = {1'b0, rd_ptr} + LEN_W'(1);
  assign hop     = rd_word[bank_sel];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bank_sel <= 1'b0;
      rd_ptr   <= '0;
    end else if (swap) begin
      bank_sel <= ~bank_sel;
      rd_ptr   <= '0;
    end else if (adv) begin
      if (ptr_inc >= len) rd_ptr <= '0;
      else                rd_ptr <= ptr_inc[CODE_AW-1:0];
    end
  end
endmodule

// File: rtl/thbpam_corr.sv
module thbpam_corr
  import thbpam_pkg::*;
#(
  parameter logic [TMPL_LEN*COEF_W-1:0] TMPL = 32'h1357_7531
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    accept,
  input  logic                    first,
  input  logic signed [SMP_W-1:0] sample,
  input  logic [TC_W-1:0]         tc,
  input  logic [NC_W-1:0]         nc,
  input  logic [NC_W-1:0]         hop,
  output logic                    in_frame,
  output logic                    frame_done,
  output logic                    bit_valid,
  output logic                    bit_data
);
  localparam logic [TC_W-1:0] WIN = TC_W'(TMPL_LEN);

  fr_state_e                state;
  logic [TC_W-1:0]          samp_cnt, pos_samp;
  logic [NC_W-1:0]          slot_cnt, pos_slot;
  logic signed [ACC_W-1:0]  acc, acc_base, acc_next, add_term;
  logic signed [COEF_W-1:0] coef;
  logic signed [PROD_W-1:0] prod;
  logic [TMPL_AW-1:0]       tidx;
  logic                     take, in_win, last_samp, last_slot;

  assign in_frame  = (state == FR_BUSY);
  assign take      = accept && (in_frame || first);
  assign pos_samp  = in_frame ? samp_cnt : '0;
  assign pos_slot  = in_frame ? slot_cnt : '0;
  assign tidx      = pos_samp[TMPL_AW-1:0];
  assign coef      = TMPL[tidx*COEF_W +: COEF_W];
  assign prod      = sample * coef;
  assign in_win    = (pos_slot == hop) && (pos_samp < WIN);
  assign add_term  = in_win ? {{(ACC_W-PROD_W){prod[PROD_W-1]}}, prod} : '0;
  assign acc_base  = in_frame ? acc : '0;
  assign acc_next  = acc_base + add_term;
  assign last_samp = (pos_samp == tc - TC_W'(1));
  assign last_slot = (pos_slot == nc - NC_W'(1));
  assign frame_done = take && last_samp && last_slot;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= FR_WAIT;
      samp_cnt  <= '0;
      slot_cnt  <= '0;
      acc       <= '0;
      bit_valid <= 1'b0;
      bit_data  <= 1'b0;
    end else begin
      bit_valid <= 1'b0;
      if (take) begin
        if (frame_done) begin
          state     <= FR_WAIT;
          bit_valid <= 1'b1;
          bit_data  <= !acc_next[ACC_W-1] && (acc_next != '0);
        end else begin
          state <= FR_BUSY;
          acc   <= acc_next;
          if (last_samp) begin
            samp_cnt <= '0;
            slot_cnt <= pos_slot + NC_W'(1);
          end else begin
            samp_cnt <= pos_samp + TC_W'(1);
            slot_cnt <= pos_slot;
          end
        end
      end
    end
  end
endmodule

// File: rtl/thbpam_rx.sv
module thbpam_rx
  import thbpam_pkg::*;
#(
  parameter logic [TMPL_LEN*COEF_W-1:0] TMPL = 32'h1357_7531
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cfg_strobe,
  input  logic [TC_W-1:0]         cfg_slot_len,
  input  logic [NC_W-1:0]         cfg_slots,
  input  logic [LEN_W-1:0]        cfg_code_len,
  input  logic                    code_we,
  input  logic [CODE_AW-1:0]      code_addr,
  input  logic [NC_W-1:0]         code_slot,
  input  logic                    s_valid,
  output logic                    s_ready,
  input  logic                    s_first,
  input  logic signed [SMP_W-1:0] s_sample,
  output logic                    bit_valid,
  output logic                    bit_data
);
  rx_cfg_t         req_cfg, act_cfg;
  logic            cfg_active, cfg_pend, cfg_apply;
  logic            in_frame, frame_done, accept;
  logic [TC_W-1:0] act_tc;
  logic [NC_W-1:0] act_nc, hop;

  assign req_cfg = '{tc: cfg_slot_len, nc: cfg_slots, len: cfg_code_len};
  assign act_tc  = act_cfg.tc;
  assign act_nc  = act_cfg.nc;
  assign s_ready = cfg_active && !cfg_apply;
  assign accept  = s_valid && s_ready;

  thbpam_cfg u_cfg (
    .clk     (clk),
    .rst_n   (rst_n),
    .strobe  (cfg_strobe),
    .new_cfg (req_cfg),
    .in_frame(in_frame),
    .act_cfg (act_cfg),
    .active  (cfg_active),
    .pend    (cfg_pend),
    .apply   (cfg_apply)
  );

  thbpam_code u_code (
    .clk  (clk),
    .rst_n(rst_n),
    .we   (code_we),
    .addr (code_addr),
    .wdata(code_slot),
    .hold (cfg_pend),
    .swap (cfg_apply),
    .adv  (frame_done),
    .len  (act_cfg.len),
    .hop  (hop)
  );

  thbpam_corr #(.TMPL(TMPL)) u_corr (
    .clk       (clk),
    .rst_n     (rst_n),
    .accept    (accept),
    .first     (s_first),
    .sample    (s_sample),
    .tc        (act_tc),
    .nc        (act_nc),
    .hop       (hop),
    .in_frame  (in_frame),
    .frame_done(frame_done),
    .bit_valid (bit_valid),
    .bit_data  (bit_data)
  );
endmodule

// File: rtl/thbpam_rx_chk.sv
module thbpam_rx_chk
  import thbpam_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic            s_valid,
  input logic            s_ready,
  input logic            bit_valid,
  input logic            cfg_active,
  input logic            in_frame,
  input logic [TC_W-1:0] act_tc,
  input logic [NC_W-1:0] act_nc,
  input logic [NC_W-1:0] hop
);
  // R1
  idle_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_active |-> !bit_valid);

  // R4
  bit_follows_xfer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bit_valid |-> $past(s_valid && s_ready));

  // R8
  cfg_frozen_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_frame && $past(in_frame)) |-> ($stable(act_tc) && $stable(act_nc)));

  // R8
  cfg_change_at_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !($stable(act_tc) && $stable(act_nc)) |-> $past(!in_frame));

  // R5
  hop_frozen_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_frame && $past(in_frame)) |-> $stable(hop));
endmodule

bind thbpam_rx thbpam_rx_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .s_valid   (s_valid),
  .s_ready   (s_ready),
  .bit_valid (bit_valid),
  .cfg_active(cfg_active),
  .in_frame  (in_frame),
  .act_tc    (act_tc),
  .act_nc    (act_nc),
  .hop       (hop)
);

// File: tb/thbpam_rx_test.sv
`timescale 1ns/1ps
module thbpam_rx_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_strobe = 1'b0;
  logic [15:0] cfg_slot_len = '0;
  logic [7:0]  cfg_slots = '0;
  logic [4:0]  cfg_code_len = '0;
  logic code_we = 1'b0;
  logic [3:0] code_addr = '0;
  logic [7:0] code_slot = '0;
  logic s_valid = 1'b0;
  logic s_first = 1'b0;
  logic signed [7:0] s_sample = '0;
  logic s_ready, bit_valid, bit_data;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  bit bit_q[$];

  always #2 clk = ~clk;

  thbpam_rx uut (
    .clk(clk), .rst_n(rst_n), .cfg_strobe(cfg_strobe), .cfg_slot_len(cfg_slot_len),
    .cfg_slots(cfg_slots), .cfg_code_len(cfg_code_len), .code_we(code_we),
    .code_addr(code_addr), .code_slot(code_slot), .s_valid(s_valid), .s_ready(s_ready),
    .s_first(s_first), .s_sample(s_sample), .bit_valid(bit_valid), .bit_data(bit_data)
  );

  // ---------------- behavioural reference ----------------
  int coef_tab[8] = '{1, 3, 5, 7, 7, 5, 3, 1};
  int tbl[2][16];
  int m_act, m_pend, m_tc, m_nc, m_len, sh_tc, sh_nc, sh_len;
  int m_sel, m_ptr, m_busy, m_samp, m_slot, m_acc, e_bv, e_bit;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_act = 0; m_pend = 0; m_tc = 0; m_nc = 0; m_len = 0;
      sh_tc = 0; sh_nc = 0; sh_len = 0; m_sel = 0; m_ptr = 0;
      m_busy = 0; m_samp = 0; m_slot = 0; m_acc = 0; e_bv = 0; e_bit = 0;
      foreach (tbl[b, i]) tbl[b][i] = 0;
    end else begin
      int app, rdy;
      app = m_pend && !m_busy;
      rdy = m_act && !app;
      e_bv = 0;
      if (s_valid && rdy && (m_busy || s_first)) begin
        int ps, pl, hop, contrib;
        ps = m_busy ? m_samp : 0;
        pl = m_busy ? m_slot : 0;
        hop = tbl[m_sel][m_ptr];
        contrib = (pl == hop && ps < 8) ? int'(s_sample) * coef_tab[ps] : 0;
        m_acc = (m_busy ? m_acc : 0) + contrib;
        if (ps == m_tc - 1 && pl == m_nc - 1) begin
          e_bv = 1;
          e_bit = (m_acc > 0);
          m_busy = 0;
          m_ptr = (m_ptr + 1 >= m_len) ? 0 : m_ptr + 1;
        end else begin
          m_busy = 1;
          if (ps == m_tc - 1) begin m_samp = 0; m_slot = pl + 1; end
          else begin m_samp = ps + 1; m_slot = pl; end
        end
      end
      if (code_we && !m_pend) tbl[1 - m_sel][code_addr] = code_slot;
      if (app) begin
        m_tc = sh_tc; m_nc = sh_nc; m_len = sh_len;
        m_sel = 1 - m_sel; m_ptr = 0; m_act = 1; m_pend = 0;
      end
      if (cfg_strobe && cfg_slot_len != 0 && cfg_slots != 0) begin
        sh_tc = cfg_slot_len; sh_nc = cfg_slots; sh_len = cfg_code_len; m_pend = 1;
      end
    end
  end

  // ---------------- per-cycle comparison ----------------
  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      check("R8 s_ready per cycle", int'(s_ready), int'(m_act && !(m_pend && !m_busy)));
      check("R4 bit_valid per cycle", int'(bit_valid), e_bv);
      if (e_bv) check("R4 bit_data per cycle", int'(bit_data), e_bit);
      if (bit_valid) bit_q.push_back(bit_data);
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic push(bit first, int val);
    @(negedge clk);
    s_valid = 1'b1; s_first = first; s_sample = 8'(val);
    while (!s_ready) @(negedge clk);
    @(negedge clk);
    s_valid = 1'b0; s_first = 1'b0;
  endtask

  task automatic strobe(int tc, int nc, int len);
    @(negedge clk);
    cfg_strobe = 1'b1; cfg_slot_len = 16'(tc); cfg_slots = 8'(nc); cfg_code_len = 5'(len);
    @(negedge clk);
    cfg_strobe = 1'b0;
  endtask

  task automatic wr_code(int a, int v);
    @(negedge clk);
    code_we = 1'b1; code_addr = 4'(a); code_slot = 8'(v);
    @(negedge clk);
    code_we = 1'b0;
  endtask

  function automatic int sval(int tc, int hop, int idx, int in_v, int out_v, int tail_v);
    int sl, ps;
    sl = idx / tc; ps = idx % tc;
    if (sl != hop) return out_v;
    return (ps < 8) ? in_v : tail_v;
  endfunction

  task automatic frame_part(int tc, int hop, int in_v, int out_v, int tail_v,
                            int from, int to, bit mid_first);
    for (int idx = from; idx < to; idx++)
      push(idx == 0 || (mid_first && idx == 5), sval(tc, hop, idx, in_v, out_v, tail_v));
  endtask

  task automatic expect_bit(string tag, int exp);
    checks++;
    if (bit_q.size() == 0) begin
      errors++;
      $display("FAIL %s actual none expected %0d", tag, exp);
    end else begin
      int got;
      got = bit_q.pop_front();
      if (got != exp) begin
        errors++;
        $display("FAIL %s actual %0d expected %0d", tag, got, exp);
      end
    end
  endtask

  task automatic std_frame(int tc, int nc, int hop, int b, string tag);
    int a;
    a = b ? 20 : -20;
    frame_part(tc, hop, a, -3 * a - 30 * (b ? 1 : -1) + 30 * (b ? 1 : -1) - (b ? 30 : -30), 0,
               0, tc * nc, 1'b0);
    idle(2);
    expect_bit(tag, b);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  // ---------------- scenarios ----------------
  initial begin
    int bits[5] = '{1, 0, 1, 1, 0};
    int hops[5] = '{1, 0, 2, 1, 0};
    idle(5);
    rst_n = 1'b1;
    idle(1);
    // R1: idle state after reset
    check("R1 s_ready after reset", int'(s_ready), 0);
    check("R1 bit_valid after reset", int'(bit_valid), 0);
    @(negedge clk); s_valid = 1'b1; s_first = 1'b1; s_sample = 8'sd40;
    idle(6);
    s_valid = 1'b0; s_first = 1'b0;
    check("R1 no bits before configuration", bit_q.size(), 0);

    // R9/R5: table [1,0,2] into standby bank, 4-sample slots, 3 slots
    wr_code(0, 1); wr_code(1, 0); wr_code(2, 2);
    strobe(4, 3, 3);
    idle(3);
    check("R1 s_ready once configured", int'(s_ready), 1);
    // R3/R5: strong opposite noise in other slots, pointer wraps at 3
    for (int f = 0; f < 5; f++) std_frame(4, 3, hops[f], bits[f], "R3 R5 hop slot decision");
    // R4: all-zero frame decides 0 (pointer now 2)
    frame_part(4, 2, 0, 0, 0, 0, 12, 1'b0);
    idle(2);
    expect_bit("R4 zero sum gives 0", 0);
    // R10: sample without start flag is discarded; start flag inside frame ignored
    push(1'b0, 100);
    frame_part(4, 1, 20, -90, 0, 0, 12, 1'b1);
    idle(2);
    check("R10 one bit per frame", bit_q.size(), 1);
    expect_bit("R10 flags handled", 1);

    // R6/R3: new bank [5,2], 10-sample slots, 3 slots, code length 2
    wr_code(0, 5); wr_code(1, 2);
    strobe(10, 3, 2);
    idle(3);
    frame_part(10, 0, 50, 50, 50, 0, 30, 1'b0);
    idle(2);
    expect_bit("R6 entry beyond slot count decides 0", 0);
    frame_part(10, 2, 1, -100, -100, 0, 30, 1'b0);
    idle(2);
    expect_bit("R3 samples past template window ignored", 1);
    frame_part(10, 2, -50, -50, -50, 0, 30, 1'b0);
    idle(2);
    expect_bit("R5 pointer wrap to entry 0", 0);

    // R8/R9: change requested mid-frame; write while pending ignored
    wr_code(0, 0);
    frame_part(10, 2, 20, -90, 20, 0, 12, 1'b0);
    strobe(2, 2, 1);
    wr_code(0, 1);
    frame_part(10, 2, 20, -90, 20, 12, 30, 1'b0);
    check("R8 s_ready low in apply cycle", int'(s_ready), 0);
    idle(2);
    expect_bit("R8 frame in progress keeps old settings", 1);
    frame_part(2, 0, 40, -40, 40, 0, 4, 1'b0);
    idle(2);
    check("R7 new frame length applied", bit_q.size(), 1);
    expect_bit("R9 write during pending ignored", 1);

    // R7: strobe with zero slot length is ignored
    strobe(0, 5, 1);
    check("R7 zero field strobe ignored", int'(s_ready), 1);
    frame_part(2, 0, 40, -40, 40, 0, 4, 1'b0);
    idle(2);
    check("R7 old frame length kept", bit_q.size(), 1);
    expect_bit("R7 decode unchanged", 1);

    // R7: last of two strobes wins, R2: gaps do not move position
    wr_code(0, 1);
    frame_part(2, 0, 40, -40, 40, 0, 2, 1'b0);
    strobe(3, 1, 1);
    strobe(1, 2, 1);
    idle(3);
    frame_part(2, 0, 40, -40, 40, 2, 4, 1'b0);
    idle(2);
    expect_bit("R2 frame across idle gaps", 1);
    push(1'b1, -50);
    idle(3);
    push(1'b0, 50);
    idle(2);
    check("R7 latest strobe sets frame length", bit_q.size(), 1);
    expect_bit("R7 latest strobe hop slot", 1);

    idle(4);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule